// File: doc/BRIEF.md
# Eager Physical Register Release Tracker

This block sits next to the rename stage of an out-of-order core that runs as the leading half of a redundant thread pair. For every physical register it keeps an "overwritten" flag, a count of renamed consumers that have not yet read it, and the index of the slot in the inter-core value queue that holds a duplicate of its value. A register is handed back to the free list when a younger rename has remapped its logical register and every counted consumer has read it. The tracker does not wait for the overwriting instruction to commit, and it does not wait for older branches to resolve. A register that never drains is freed in the usual way when the overwriting instruction commits, and no register is released twice.

Releasing registers this early is only safe because the trailing thread keeps a second copy of every value. On a branch mispredict the reorder buffer replays the mappings to restore, one per cycle. If a restored mapping points at a register that has already been released, the tracker issues a copy-back request naming the value-queue slot to refill from. If the register is still live, the tracker clears its overwritten flag and removes the counts added by the squashed consumers.

Recovery is sequenced by a three-state machine:
- RC_IDLE goes to RC_RESTORE on a non-final entry.
- RC_IDLE or RC_RESTORE goes to RC_COPY on the final entry if any copy-back was issued.
- RC_IDLE or RC_RESTORE goes back to RC_IDLE on the final entry if no copy-back was issued.
- RC_COPY returns to RC_IDLE after a fixed copy-back latency of CB_LAT cycles.

Renames are stalled while a recovery entry is present or the machine is not in RC_IDLE. They are also stalled when accepting a rename would push a consumer count past its maximum.

Top module: `erl_tracker`

## Requirements
- R1: After reset `rel_valid`, `cb_valid`, `rec_busy` and `ren_stall` are 0, and no register is released until it has been renamed in.
- R2: A register whose logical register has been renamed again is released while its consumer count is zero, before the overwriter commits. `rel_valid` pulses with `rel_preg` on the second rising edge after the event that made it eligible.
- R3: A register is not released eagerly while any renamed consumer has not yet read it. The final read makes it eligible.
- R4: A commit naming a register that has not been released (`cmt_valid`, `cmt_old`) releases it even if consumers are still counted.
- R5: A register is released at most once per allocation. A later commit or read of it produces no release.
- R6: When several registers become eligible in the same cycle, they are released one per cycle, lowest index first.
- R7: A recovery entry whose `rec_preg` has already been released produces `cb_valid` one cycle later. The pulse carries that register in `cb_preg` and the queue index recorded at its allocation in `cb_vq`.
- R8: A recovery entry for a register that has not been released clears its overwritten flag and subtracts `rec_drop` from its count. Reaching zero then does not release it, but a later overwrite does.
- R9: After a final recovery entry that issued a copy-back, `rec_busy` stays 1 for exactly CB_LAT (5) cycles. Renames offered while it is 1 assert `ren_stall` and are ignored.
- R10: Counts saturate at 2^CNT_W-1 (7). A rename that would exceed this asserts `ren_stall` and is ignored.
- R11: A rename whose two source ports name the same register adds two to its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename event offered |
| ren_dst | input | PW | Newly allocated destination register |
| ren_dst_vq | input | VQ_W | Value-queue slot holding the duplicate of the destination |
| ren_old_vld | input | 1 | Destination logical register had a previous mapping |
| ren_old | input | PW | Previous mapping, now overwritten |
| ren_s0_vld | input | 1 | Source 0 present |
| ren_s0 | input | PW | Source 0 register |
| ren_s1_vld | input | 1 | Source 1 present |
| ren_s1 | input | PW | Source 1 register |
| ren_stall | output | 1 | Rename not accepted this cycle |
| rd0_valid | input | 1 | Operand read on port 0 |
| rd0_preg | input | PW | Register read on port 0 |
| rd1_valid | input | 1 | Operand read on port 1 |
| rd1_preg | input | PW | Register read on port 1 |
| cmt_valid | input | 1 | Overwriting instruction committed |
| cmt_old | input | PW | Register it overwrote |
| rec_valid | input | 1 | Recovery entry present |
| rec_preg | input | PW | Register of the restored mapping |
| rec_drop | input | CNT_W | Squashed consumer count to remove |
| rec_last | input | 1 | Final entry of this recovery |
| rel_valid | output | 1 | Release pulse to the free list |
| rel_preg | output | PW | Released register |
| cb_valid | output | 1 | Copy-back request |
| cb_preg | output | PW | Released register being rebuilt |
| cb_vq | output | VQ_W | Value-queue slot to read the value from |
| rec_busy | output | 1 | Recovery machine not idle |

## Verification
Release timing is tested under four event orders, each of which tells a different cause of release apart:
- an overwrite that comes before the last read, so only draining can free the register;
- a commit that comes while a consumer is still pending, so only the conventional path can free it;
- two drains in the same cycle, so the release order becomes visible;
- one consumer with both sources on the same register, so it must be counted twice.

Recovery is tested with a restored register that was already freed, which must produce a copy-back and the timed busy window. It is also tested with a restored register that is still live, where a stale release after the rollback would reveal that the overwritten flag was not cleared. Saturation is checked by counting the reads needed to free a register after a refused eighth consumer.

// File: rtl/erl_pkg.sv
package erl_pkg;
    typedef enum logic [1:0] {
        RC_IDLE    = 2'd0,
        RC_RESTORE = 2'd1,
        RC_COPY    = 2'd2
    } rc_state_e;
endpackage

// File: rtl/erl_entry.sv
module erl_entry #(
    parameter int CNT_W = 3,
    parameter int VQ_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [VQ_W-1:0]  vq_i,
    input  logic             ovw_set_i,
    input  logic             take_i,
    input  logic [1:0]       inc_i,
    input  logic [1:0]       dec_i,
    input  logic             restore_i,
    input  logic [CNT_W-1:0] drop_i,
    input  logic             commit_i,
    input  logic             release_i,
    output logic             pending_o,
    output logic             released_o,
    output logic             ovf_o,
    output logic [VQ_W-1:0]  vq_o
);
    localparam int EW = CNT_W + 2;
    localparam logic [EW-1:0] CNT_MAX = EW'((1 << CNT_W) - 1);

    logic             live_q, ovw_q, rel_q, due_q;
    logic [CNT_W-1:0] cnt_q;
    logic [VQ_W-1:0]  vq_q;
    logic [EW-1:0]    up, sub, nxt;

    always_comb begin
        up  = EW'(cnt_q) + (take_i ? EW'(inc_i) : '0);
        sub = EW'(dec_i) + (restore_i ? EW'(drop_i) : '0);
        nxt = (up > sub) ? (up - sub) : '0;
        if (nxt > CNT_MAX) nxt = CNT_MAX;
    end

    assign ovf_o = (EW'(cnt_q) + EW'(inc_i)) > CNT_MAX;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            ovw_q  <= 1'b0;
            rel_q  <= 1'b0;
            due_q  <= 1'b0;
            cnt_q  <= '0;
            vq_q   <= '0;
        end else if (alloc_i) begin
            live_q <= 1'b1;
            ovw_q  <= 1'b0;
            rel_q  <= 1'b0;
            due_q  <= 1'b0;
            cnt_q  <= '0;
            vq_q   <= vq_i;
        end else begin
            if (restore_i && !rel_q) ovw_q <= 1'b0;
            else if (ovw_set_i)      ovw_q <= 1'b1;
            cnt_q <= nxt[CNT_W-1:0];
            if (restore_i)                due_q <= 1'b0;
            else if (commit_i && !rel_q)  due_q <= 1'b1;
            if (release_i) rel_q <= 1'b1;
        end
    end

    assign pending_o  = live_q && !rel_q && ((ovw_q && cnt_q == '0) || due_q);
    assign released_o = rel_q;
    assign vq_o       = vq_q;

    // R5: a grant never lands on a register already handed back
    p_release_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> (live_q && !rel_q));

    // R3: an eager grant only after every consumer has read
    p_release_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !due_q) |-> (cnt_q == '0));
endmodule

// File: rtl/erl_pick.sv
module erl_pick #(
    parameter int N  = 16,
    parameter int PW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [PW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = PW'(i);
        end
        any_o   = |req_i;
        grant_o = any_o ? (N'(1) << idx_o) : '0;
    end
endmodule

// File: rtl/erl_recov_fsm.sv
module erl_recov_fsm
    import erl_pkg::*;
#(
    parameter int CB_LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rec_valid_i,
    input  logic rec_last_i,
    input  logic cb_hit_i,
    output logic busy_o
);
    localparam int WW = $clog2(CB_LAT + 1);

    rc_state_e     state_q, state_d;
    logic          hit_q;
    logic [WW-1:0] wait_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RC_IDLE: begin
                if (rec_valid_i)
                    state_d = rec_last_i ? (cb_hit_i ? RC_COPY : RC_IDLE) : RC_RESTORE;
            end
            RC_RESTORE: begin
                if (rec_valid_i && rec_last_i)
                    state_d = (hit_q || cb_hit_i) ? RC_COPY : RC_IDLE;
            end
            RC_COPY: begin
                if (wait_q == WW'(CB_LAT - 1)) state_d = RC_IDLE;
            end
            default: state_d = RC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RC_IDLE;
            hit_q   <= 1'b0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            hit_q   <= (state_d == RC_RESTORE) ? (hit_q || (rec_valid_i && cb_hit_i)) : 1'b0;
            wait_q  <= (state_q == RC_COPY) ? wait_q + 1'b1 : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            RC_IDLE:    busy_o = 1'b0;
            RC_RESTORE: busy_o = 1'b1;
            RC_COPY:    busy_o = 1'b1;
            default:    busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/erl_tracker.sv
module erl_tracker #(
    parameter int NPREG  = 16,
    parameter int CNT_W  = 3,
    parameter int VQ_W   = 6,
    parameter int CB_LAT = 5,
    parameter int PW     = $clog2(NPREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid,
    input  logic [PW-1:0]    ren_dst,
    input  logic [VQ_W-1:0]  ren_dst_vq,
    input  logic             ren_old_vld,
    input  logic [PW-1:0]    ren_old,
    input  logic             ren_s0_vld,
    input  logic [PW-1:0]    ren_s0,
    input  logic             ren_s1_vld,
    input  logic [PW-1:0]    ren_s1,
    output logic             ren_stall,
    input  logic             rd0_valid,
    input  logic [PW-1:0]    rd0_preg,
    input  logic             rd1_valid,
    input  logic [PW-1:0]    rd1_preg,
    input  logic             cmt_valid,
    input  logic [PW-1:0]    cmt_old,
    input  logic             rec_valid,
    input  logic [PW-1:0]    rec_preg,
    input  logic [CNT_W-1:0] rec_drop,
    input  logic             rec_last,
    output logic             rel_valid,
    output logic [PW-1:0]    rel_preg,
    output logic             cb_valid,
    output logic [PW-1:0]    cb_preg,
    output logic [VQ_W-1:0]  cb_vq,
    output logic             rec_busy
);
    logic [NPREG-1:0] pending, released, ovf, grant;
    logic [VQ_W-1:0]  vq_arr [NPREG];
    logic             ren_ok, cb_hit, pick_any;
    logic [PW-1:0]    pick_idx;

    assign ren_stall = rec_busy || rec_valid || (ren_valid && (|ovf));
    assign ren_ok    = ren_valid && !ren_stall;

    for (genvar g = 0; g < NPREG; g++) begin : g_entry
        logic s0h, s1h, r0h, r1h;
        assign s0h = ren_s0_vld && (ren_s0 == PW'(g));
        assign s1h = ren_s1_vld && (ren_s1 == PW'(g));
        assign r0h = rd0_valid && (rd0_preg == PW'(g));
        assign r1h = rd1_valid && (rd1_preg == PW'(g));

        erl_entry #(.CNT_W(CNT_W), .VQ_W(VQ_W)) i_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (ren_ok && (ren_dst == PW'(g))),
            .vq_i       (ren_dst_vq),
            .ovw_set_i  (ren_ok && ren_old_vld && (ren_old == PW'(g))),
            .take_i     (ren_ok),
            .inc_i      ({1'b0, s0h} + {1'b0, s1h}),
            .dec_i      ({1'b0, r0h} + {1'b0, r1h}),
            .restore_i  (rec_valid && (rec_preg == PW'(g))),
            .drop_i     (rec_drop),
            .commit_i   (cmt_valid && (cmt_old == PW'(g))),
            .release_i  (grant[g]),
            .pending_o  (pending[g]),
            .released_o (released[g]),
            .ovf_o      (ovf[g]),
            .vq_o       (vq_arr[g])
        );
    end

    erl_pick #(.N(NPREG), .PW(PW)) i_pick (
        .req_i   (pending & {NPREG{!rec_valid}}),
        .grant_o (grant),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    assign cb_hit = rec_valid && released[rec_preg];

    erl_recov_fsm #(.CB_LAT(CB_LAT)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_valid_i (rec_valid),
        .rec_last_i  (rec_last),
        .cb_hit_i    (cb_hit),
        .busy_o      (rec_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_preg  <= '0;
            cb_valid  <= 1'b0;
            cb_preg   <= '0;
            cb_vq     <= '0;
        end else begin
            rel_valid <= pick_any;
            rel_preg  <= pick_idx;
            cb_valid  <= cb_hit;
            cb_preg   <= rec_preg;
            cb_vq     <= vq_arr[rec_preg];
        end
    end

    // R7: copy-back only follows a recovery entry
    p_cb_after_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cb_valid |-> $past(rec_valid));

    // R5: back-to-back releases never repeat a register
    p_rel_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && $past(rel_valid)) |-> (rel_preg != $past(rel_preg)));
endmodule

// File: tb/test_erl_tracker.sv
`timescale 1ns/100ps
module test_erl_tracker;
    localparam int PW = 4;
    localparam int VQ_W = 6;
    localparam int CNT_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ren_valid = 0, ren_old_vld = 0, ren_s0_vld = 0, ren_s1_vld = 0;
    logic [PW-1:0] ren_dst = 0, ren_old = 0, ren_s0 = 0, ren_s1 = 0;
    logic [VQ_W-1:0] ren_dst_vq = 0;
    logic rd0_valid = 0, rd1_valid = 0, cmt_valid = 0, rec_valid = 0, rec_last = 0;
    logic [PW-1:0] rd0_preg = 0, rd1_preg = 0, cmt_old = 0, rec_preg = 0;
    logic [CNT_W-1:0] rec_drop = 0;
    logic ren_stall, rel_valid, cb_valid, rec_busy;
    logic [PW-1:0] rel_preg, cb_preg;
    logic [VQ_W-1:0] cb_vq;

    int checks = 0, failures = 0, rel_n = 0;
    int rel_log [64];

    always #2.5 clk = ~clk;

    erl_tracker i_erl_tracker (.*);

    always @(posedge clk) begin
        #1;
        if (rst_n && rel_valid && rel_n < 64) begin
            rel_log[rel_n] = int'(rel_preg);
            rel_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ren(input int dst, input int vq, input bit ov, input int old,
                       input bit v0, input int s0, input bit v1, input int s1);
        ren_valid = 1; ren_dst = PW'(dst); ren_dst_vq = VQ_W'(vq);
        ren_old_vld = ov; ren_old = PW'(old);
        ren_s0_vld = v0; ren_s0 = PW'(s0); ren_s1_vld = v1; ren_s1 = PW'(s1);
        @(negedge clk);
        ren_valid = 0; ren_old_vld = 0; ren_s0_vld = 0; ren_s1_vld = 0;
    endtask

    task automatic rd(input bit v0, input int p0, input bit v1, input int p1);
        rd0_valid = v0; rd0_preg = PW'(p0); rd1_valid = v1; rd1_preg = PW'(p1);
        @(negedge clk);
        rd0_valid = 0; rd1_valid = 0;
    endtask

    task automatic cmt(input int p);
        cmt_valid = 1; cmt_old = PW'(p);
        @(negedge clk);
        cmt_valid = 0;
    endtask

    task automatic t_reset;
        chk(rel_valid == 0, "R1 rel_valid", int'(rel_valid), 0);
        chk(cb_valid == 0, "R1 cb_valid", int'(cb_valid), 0);
        chk(rec_busy == 0, "R1 rec_busy", int'(rec_busy), 0);
        chk(ren_stall == 0, "R1 ren_stall", int'(ren_stall), 0);
        rd(1, 3, 0, 0);
        idle(3);
        chk(rel_n == 0, "R1 no release before rename", rel_n, 0);
    endtask

    task automatic t_eager;
        int b;
        ren(1, 1, 0, 0, 0, 0, 0, 0);
        ren(2, 2, 0, 0, 1, 1, 0, 0);
        ren(3, 3, 1, 1, 0, 0, 0, 0);
        b = rel_n;
        idle(4);
        chk(rel_n == b, "R3 held while consumer pending", rel_n - b, 0);
        rd(1, 1, 0, 0);
        // eligible at edge after read, pulse at following edge
        @(negedge clk);
        chk(rel_n == b + 1 && rel_log[b] == 1, "R2 eager release of 1", rel_n - b, 1);
        cmt(1);
        idle(3);
        chk(rel_n == b + 1, "R5 commit after eager release", rel_n - b, 1);
    endtask

    task automatic t_commit;
        int b;
        ren(4, 4, 0, 0, 0, 0, 0, 0);
        ren(5, 5, 0, 0, 1, 4, 0, 0);
        ren(6, 6, 1, 4, 0, 0, 0, 0);
        b = rel_n;
        cmt(4);
        idle(2);
        chk(rel_n == b + 1 && rel_log[b] == 4, "R4 commit release of 4", rel_n - b, 1);
        rd(1, 4, 0, 0);
        idle(3);
        chk(rel_n == b + 1, "R5 drain after commit release", rel_n - b, 1);
    endtask

    task automatic t_order;
        int b;
        ren(7, 7, 0, 0, 0, 0, 0, 0);
        ren(8, 8, 0, 0, 0, 0, 0, 0);
        ren(11, 11, 0, 0, 1, 7, 1, 8);
        ren(12, 12, 1, 7, 0, 0, 0, 0);
        ren(13, 13, 1, 8, 0, 0, 0, 0);
        b = rel_n;
        rd(1, 8, 1, 7);
        idle(3);
        chk(rel_n == b + 2, "R6 both released", rel_n - b, 2);
        chk(rel_log[b] == 7 && rel_log[b+1] == 8, "R6 lowest first", rel_log[b], 7);
    endtask

    task automatic t_dual;
        int b;
        ren(14, 14, 0, 0, 0, 0, 0, 0);
        ren(15, 15, 0, 0, 1, 14, 1, 14);
        ren(0, 0, 1, 14, 0, 0, 0, 0);
        b = rel_n;
        rd(1, 14, 0, 0);
        idle(3);
        chk(rel_n == b, "R11 one of two reads", rel_n - b, 0);
        rd(1, 14, 0, 0);
        idle(3);
        chk(rel_n == b + 1 && rel_log[b] == 14, "R11 second read frees 14", rel_n - b, 1);
    endtask

    task automatic t_copyback;
        int b, busy_n;
        ren(2, 42, 0, 0, 0, 0, 0, 0);
        ren(3, 3, 1, 2, 0, 0, 0, 0);
        idle(3);
        b = rel_n;
        rec_valid = 1; rec_preg = 2; rec_drop = 0; rec_last = 1;
        @(negedge clk);
        rec_valid = 0; rec_last = 0;
        chk(cb_valid == 1, "R7 cb_valid", int'(cb_valid), 1);
        chk(cb_vq == 42, "R7 cb_vq", int'(cb_vq), 42);
        chk(cb_preg == 2, "R7 cb_preg", int'(cb_preg), 2);
        busy_n = 0;
        for (int k = 0; k < 8; k++) begin
            if (rec_busy) busy_n++;
            if (k == 0) begin
                ren_valid = 1; ren_dst = 10; ren_old_vld = 1; ren_old = 15;
                #1;
                chk(ren_stall == 1, "R9 stall while busy", int'(ren_stall), 1);
            end
            @(negedge clk);
            ren_valid = 0; ren_old_vld = 0;
        end
        chk(busy_n == 5, "R9 busy window", busy_n, 5);
        idle(3);
        chk(rel_n == b, "R9 stalled rename ignored", rel_n - b, 0);
    endtask

    task automatic t_rollback;
        int b;
        ren(4, 4, 0, 0, 0, 0, 0, 0);
        ren(5, 5, 0, 0, 1, 4, 0, 0);
        ren(6, 6, 0, 0, 1, 4, 0, 0);
        ren(7, 7, 1, 4, 0, 0, 0, 0);
        rd(1, 4, 0, 0);
        b = rel_n;
        rec_valid = 1; rec_preg = 4; rec_drop = 1; rec_last = 1;
        @(negedge clk);
        rec_valid = 0; rec_last = 0; rec_drop = 0;
        idle(4);
        chk(rel_n == b && cb_valid == 0, "R8 restored live reg kept", rel_n - b, 0);
        ren(8, 8, 1, 4, 0, 0, 0, 0);
        idle(2);
        chk(rel_n == b + 1 && rel_log[b] == 4, "R8 later overwrite frees 4", rel_n - b, 1);
    endtask

    task automatic t_saturate;
        int b;
        ren(9, 9, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 7; k++) ren(10, 10, 0, 0, 1, 9, 0, 0);
        ren_valid = 1; ren_dst = 10; ren_s0_vld = 1; ren_s0 = 9;
        #1;
        chk(ren_stall == 1, "R10 stall at full count", int'(ren_stall), 1);
        @(negedge clk);
        ren_valid = 0; ren_s0_vld = 0;
        ren(11, 11, 1, 9, 0, 0, 0, 0);
        b = rel_n;
        for (int k = 0; k < 6; k++) rd(1, 9, 0, 0);
        idle(3);
        chk(rel_n == b, "R10 six reads leave one", rel_n - b, 0);
        rd(1, 9, 0, 0);
        idle(2);
        chk(rel_n == b + 1 && rel_log[b] == 9, "R10 seventh read frees 9", rel_n - b, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_eager;
        t_commit;
        t_order;
        t_dual;
        t_copyback;
        t_rollback;
        t_saturate;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule